// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a virtual address into a physical address by fetching one entry from a flat page table in memory. A request carries the virtual address, an access kind (read or write) and a privilege level (user or supervisor). The entry sits at a table base, given on the `ptbr` input, plus the virtual page number times four bytes. The walker fetches that entry through a request/acknowledge read port. It then checks the entry's present, writable and user-permitted bits and answers with one of three outcomes: a physical address, a not-present fault or a permission fault.

After a permitted access, the walker sets the entry's accessed flag, and also its dirty flag when the access is a write. The updated entry is written back through a request/acknowledge write port, but only when one of those two flags actually changed. The walker handles one translation at a time. It accepts no new request until the response has been taken.

Top module: `pt_walker`

## Requirements
- R1: The low `OFS_W` bits of the virtual address pass through unchanged. On success, the physical address is the entry's frame field (entry bits starting at bit 12) shifted left by `OFS_W`, ORed with those offset bits. With 16-byte pages, virtual address 21 whose entry holds frame 7 gives physical address 117.
- R2: Each translation issues exactly one read, at byte address `ptbr + VPN*4`, where VPN is the virtual address above the offset.
- R3: If entry bit 0 (present) is 0, the response status is 1 (not present) and the physical address is 0. No write-back takes place.
- R4: If the entry is present, the access is a write and entry bit 1 (writable) is 0, the status is 2 (permission fault) and the physical address is 0.
- R5: If the entry is present, the access is user-level and entry bit 2 (user permitted) is 0, the status is 2 (permission fault) and the physical address is 0.
- R6: Entry bits 3, 4, 7 and 8 have no effect on the status or the physical address.
- R7: On success (status 0), the walker sets bit 5 (accessed), and also bit 6 (dirty) on a write. It writes the entry back to the same address only when this changes the entry. It writes nothing after a fault.
- R8: `req_ready` is high only while the walker is idle. A response stays valid with a stable status and address until `rsp_ready` is high at a clock edge.
- R9: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0.
- R10: With a memory that acknowledges one cycle after a request is raised, `rsp_valid` rises 3 clock edges after acceptance when there is no write-back, and 5 edges after acceptance with a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| ptbr | input | PA_W | Page table base byte address, sampled at acceptance |
| mem_rd_req | output | 1 | Entry read request, held until acknowledged |
| mem_rd_addr | output | PA_W | Entry byte address |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 32 | Entry read data |
| mem_wr_req | output | 1 | Entry write-back request, held until acknowledged |
| mem_wr_addr | output | PA_W | Write-back byte address |
| mem_wr_data | output | 32 | Updated entry |
| mem_wr_ack | input | 1 | Write acknowledge |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_status | output | 2 | 0 ok, 1 not present, 2 permission fault |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |

## Verification
Once a request is accepted, the entry read is acknowledged one edge later in the bench memory. The response then becomes valid on the third edge after acceptance, or on the fifth edge when a write-back is needed. The bench counts edges from acceptance and samples one nanosecond after each edge. It checks the measured count against the value predicted from the entry flags and the access kind. The read count, the read address and the table contents are checked after the response has been consumed. Status and address are taken at the first cycle `rsp_valid` is seen, and are compared again after held-off cycles of `rsp_ready`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTE_W       = 32;
    localparam int ENTRY_BYTES = 4;
    localparam int IDX_SHIFT   = $clog2(ENTRY_BYTES);

    // entry flag positions decoded by the permission logic
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER     = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY    = 6;
    localparam int FRAME_LSB    = 12;

    typedef enum logic [1:0] {
        XLAT_OK   = 2'd0,
        XLAT_SEGV = 2'd1,
        XLAT_PROT = 2'd2
    } xlat_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_WBACK,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic write;
        logic user;
    } acc_kind_t;

    function automatic xlat_status_e judge(input logic [PTE_W-1:0] pte, input acc_kind_t k);
        if (!pte[BIT_PRESENT])
            return XLAT_SEGV;
        if ((k.write && !pte[BIT_WRITABLE]) || (k.user && !pte[BIT_USER]))
            return XLAT_PROT;
        return XLAT_OK;
    endfunction

    function automatic logic [PTE_W-1:0] mark_used(input logic [PTE_W-1:0] pte, input acc_kind_t k);
        logic [PTE_W-1:0] m;
        m = pte;
        m[BIT_ACCESSED] = 1'b1;
        if (k.write)
            m[BIT_DIRTY] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFS_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  entry_addr,
    output logic [OFS_W-1:0] offset
);
    localparam int VPN_W = VA_W - OFS_W;

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  vpn_ext;

    assign vpn     = vaddr[VA_W-1:OFS_W];
    assign offset  = vaddr[OFS_W-1:0];
    assign vpn_ext = PA_W'(vpn);

    assign entry_addr = base + (vpn_ext << IDX_SHIFT);

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFS_W = 12
) (
    input  logic [PTE_W-1:0] pte,
    input  acc_kind_t        kind,
    input  logic [OFS_W-1:0] offset,
    output xlat_status_e     status,
    output logic [PA_W-1:0]  paddr,
    output logic [PTE_W-1:0] new_pte,
    output logic             need_wb
);
    localparam int PFN_W = PA_W - OFS_W;

    logic [PFN_W-1:0] frame;

    assign frame   = pte[FRAME_LSB +: PFN_W];
    assign status  = judge(pte, kind);
    assign new_pte = mark_used(pte, kind);

    always_comb begin
        if (status == XLAT_OK) begin
            paddr   = {frame, offset};
            need_wb = (new_pte != pte);
        end else begin
            paddr   = '0;
            need_wb = 1'b0;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFS_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic [PA_W-1:0] ptbr,
    output logic            mem_rd_req,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_ack,
    input  logic [31:0]     mem_rd_data,
    output logic            mem_wr_req,
    output logic [PA_W-1:0] mem_wr_addr,
    output logic [31:0]     mem_wr_data,
    input  logic            mem_wr_ack,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [1:0]      rsp_status,
    output logic [PA_W-1:0] rsp_paddr
);
    walk_state_e      state;
    logic [VA_W-1:0]  vaddr_q;
    logic [PA_W-1:0]  base_q;
    acc_kind_t        kind_q;
    logic [PTE_W-1:0] pte_q;
    logic [PTE_W-1:0] wb_q;
    xlat_status_e     status_q;
    logic [PA_W-1:0]  paddr_q;

    logic [PA_W-1:0]  entry_addr;
    logic [OFS_W-1:0] offset;
    xlat_status_e     chk_status;
    logic [PA_W-1:0]  chk_paddr;
    logic [PTE_W-1:0] chk_new;
    logic             chk_wb;

    ptw_entry_addr #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_addr (
        .vaddr      (vaddr_q),
        .base       (base_q),
        .entry_addr (entry_addr),
        .offset     (offset)
    );

    ptw_perm_check #(.PA_W(PA_W), .OFS_W(OFS_W)) u_check (
        .pte     (pte_q),
        .kind    (kind_q),
        .offset  (offset),
        .status  (chk_status),
        .paddr   (chk_paddr),
        .new_pte (chk_new),
        .need_wb (chk_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            vaddr_q  <= '0;
            base_q   <= '0;
            kind_q   <= '0;
            pte_q    <= '0;
            wb_q     <= '0;
            status_q <= XLAT_OK;
            paddr_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q      <= req_vaddr;
                    base_q       <= ptbr;
                    kind_q.write <= req_write;
                    kind_q.user  <= req_user;
                    state        <= ST_FETCH;
                end
                ST_FETCH: if (mem_rd_ack) begin
                    pte_q <= mem_rd_data;
                    state <= ST_EVAL;
                end
                ST_EVAL: begin
                    status_q <= chk_status;
                    paddr_q  <= chk_paddr;
                    wb_q     <= chk_new;
                    state    <= chk_wb ? ST_WBACK : ST_RESP;
                end
                ST_WBACK: if (mem_wr_ack) state <= ST_RESP;
                ST_RESP:  if (rsp_ready)  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign mem_rd_req  = (state == ST_FETCH);
    assign mem_rd_addr = entry_addr;
    assign mem_wr_req  = (state == ST_WBACK);
    assign mem_wr_addr = entry_addr;
    assign mem_wr_data = wb_q;
    assign rsp_valid   = (state == ST_RESP);
    assign rsp_status  = status_q;
    assign rsp_paddr   = paddr_q;

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req && mem_rd_ack |=> !mem_rd_req); // R2
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status != XLAT_OK |-> rsp_paddr == '0); // R3
    AST_WB_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> status_q == XLAT_OK); // R7
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> mem_wr_data[BIT_ACCESSED]); // R7
    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && kind_q.write |-> mem_wr_data[BIT_DIRTY]); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rsp_valid && !mem_rd_req && !mem_wr_req); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_paddr)); // R8

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/100ps
module pt_walker_test;
    localparam int VA_W = 6, PA_W = 8, OFS_W = 4;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_user = 0, rsp_ready = 0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [PA_W-1:0] ptbr = '0;
    logic req_ready, mem_rd_req, mem_wr_req, rsp_valid;
    logic [PA_W-1:0] mem_rd_addr, mem_wr_addr, rsp_paddr;
    logic [31:0] mem_wr_data;
    logic [1:0] rsp_status;
    logic rd_ack = 0, wr_ack = 0;
    logic [31:0] rd_data = '0;
    logic [31:0] mem [64];
    int rd_cnt = 0, wr_cnt = 0;
    logic [PA_W-1:0] last_rd_addr = '0;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user), .ptbr(ptbr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(rd_ack), .mem_rd_data(rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(wr_ack),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    always @(posedge clk) begin
        rd_ack  <= mem_rd_req && !rd_ack;
        rd_data <= mem[mem_rd_addr[7:2]];
        wr_ack  <= mem_wr_req && !wr_ack;
        if (mem_rd_req && rd_ack) begin
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= mem_rd_addr;
        end
        if (mem_wr_req && wr_ack) begin
            mem[mem_wr_addr[7:2]] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic run_xlat(input logic [7:0] base, input logic [5:0] va, input bit wr, input bit usr,
                            input int hold, output logic [1:0] st, output logic [7:0] pa, output int lat);
        bit busy_bad = 0;
        req_vaddr = va; req_write = wr; req_user = usr; ptbr = base; req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) busy_bad = 1;
            @(posedge clk); #1;
            lat++;
        end
        chk(!busy_bad, "R8 ready low while busy", busy_bad, 0);
        if (!rsp_valid) chk(0, "R8 response timeout", lat, 0);
        st = rsp_status; pa = rsp_paddr;
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk(rsp_valid && rsp_status == st && rsp_paddr == pa, "R8 response held",
                {rsp_valid, rsp_status, rsp_paddr}, {1'b1, st, pa});
        end
        rsp_ready = 1;
        @(posedge clk); #1;
        rsp_ready = 0;
        chk(!rsp_valid && req_ready, "R8 return to idle", {rsp_valid, req_ready}, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [1:0] st;
        logic [7:0] pa;
        int lat, n, r0, w0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        chk(req_ready && !rsp_valid && !mem_rd_req && !mem_wr_req, "R9 reset state",
            {req_ready, rsp_valid, mem_rd_req, mem_wr_req}, 4'b1000);

        // directed example: address 21, entry 1 holds frame 7
        mem[17] = (32'd7 << 12) | 32'h7;
        run_xlat(8'h40, 6'd21, 0, 0, 0, st, pa, lat);
        chk(st == 2'd0 && pa == 8'd117, "R1 example 21 to 117", pa, 117);
        chk(mem[17] == ((32'd7 << 12) | 32'h27), "R7 example accessed set", mem[17], (7 << 12) | 'h27);

        n = 0;
        for (int b = 0; b < 2; b++) begin
            for (int vpn = 0; vpn < 4; vpn++) begin
                for (int f = 0; f < 32; f++) begin
                    for (int a = 0; a < 4; a++) begin
                        logic [7:0] base;
                        logic [31:0] pte, npte;
                        logic [3:0] frm, ofs;
                        logic [1:0] est;
                        bit wr, usr, wb;
                        int idx;
                        base = b ? 8'hA0 : 8'h40;
                        idx  = base[7:2] + vpn;
                        wr = a[0]; usr = a[1];
                        frm = 4'((vpn * 5 + f + b * 3) & 15);
                        ofs = 4'(n & 15);
                        pte = {16'd0, frm, 3'd0, n[4], n[5], 2'b00, n[6], n[7], 3'd0};
                        pte[0] = f[0]; pte[1] = f[1]; pte[2] = f[2]; pte[5] = f[3]; pte[6] = f[4];
                        mem[idx] = pte;
                        if (!pte[0]) est = 2'd1;
                        else if ((wr && !pte[1]) || (usr && !pte[2])) est = 2'd2;
                        else est = 2'd0;
                        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                        wb = (est == 2'd0) && (npte != pte);
                        r0 = rd_cnt; w0 = wr_cnt;
                        run_xlat(base, {2'(vpn), ofs}, wr, usr, (n % 5 == 0) ? 2 : 0, st, pa, lat);
                        chk(st == est, est == 2'd1 ? "R3 status" : (wr && !pte[1] ? "R4 status" :
                            (usr && !pte[2] ? "R5 status" : "R6 status")), st, est);
                        chk(pa == (est == 2'd0 ? {frm, ofs} : 8'd0), "R1 physical address",
                            pa, est == 2'd0 ? {frm, ofs} : 8'd0);
                        chk(rd_cnt - r0 == 1 && last_rd_addr == 8'(base + vpn * 4), "R2 entry read",
                            last_rd_addr, base + vpn * 4);
                        chk(wr_cnt - w0 == (wb ? 1 : 0) && mem[idx] == (wb ? npte : pte), "R7 write-back",
                            mem[idx], wb ? npte : pte);
                        chk(lat == (wb ? 5 : 3), "R10 latency", lat, wb ? 5 : 3);
                        n++;
                    end
                end
            end
        end
        summary();
    end
endmodule